// File: doc/BRIEF.md
# Transmit Queue Doorbell and Stop Register

This block holds the doorbell and halt state for four transmit queues: beacon, high, normal and low priority. A host writes one byte to ring doorbells or to halt queues. Each doorbell marks its queue as having work for the transmit DMA. The transmit engine reports the end of a queue's transmission on a per-queue completion strobe, and that clears the doorbell. The DMA itself sits outside this block.

Which host writes take effect depends on the bit and on a descriptor-polling test-mode flag. The beacon doorbell is owned by hardware. The normal doorbell obeys the host only in polling mode, and hardware can always request it. The stop-beacon and stop-normal bits are ignored in polling mode. A halted queue keeps its doorbell, but its pending output is masked. A status byte returns the raw doorbells and the stop bits.

Top module: `txq_doorbell`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every doorbell, every stop bit, `pend_o` and `status_o` are 0.
- R2: One clock after a host write with bit 6 set, the high doorbell is 1. One clock after a host write with bit 4 set, the low doorbell is 1.
- R3: One clock after `tx_done[q]` is pulsed with no set request for queue q, doorbell q is 0. The index q is 3 for beacon, 2 for high, 1 for normal and 0 for low.
- R4: A host write with bit 7 set does not change the beacon doorbell. `hw_beacon_req` sets the beacon doorbell one clock later.
- R5: A host write with bit 5 set rings the normal doorbell only when `poll_mode` is 1. `hw_normal_req` sets the normal doorbell one clock later, whatever `poll_mode` is.
- R6: A write bit of 0 leaves the matching doorbell or stop bit unchanged.
- R7: When a set request and `tx_done` reach the same queue in the same cycle, the doorbell ends up at 1.
- R8: A host write with bit 3, 2, 1 or 0 set halts the beacon, high, normal or low queue respectively. The stop bit holds at 1 until reset.
- R9: While `poll_mode` is 1, host writes to bit 3 (stop beacon) and bit 1 (stop normal) have no effect.
- R10: `pend_o[q]` is doorbell q AND NOT stop q, with the same queue index as R3.
- R11: `status_o` is {beacon, high, normal, low doorbells, stop beacon, stop high, stop normal, stop low}, from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte (bits 7..4 doorbells, bits 3..0 stops) |
| poll_mode | input | 1 | Descriptor-polling test mode flag |
| tx_done | input | 4 | Per-queue completion strobes (3 beacon .. 0 low) |
| hw_beacon_req | input | 1 | Hardware request to ring the beacon doorbell |
| hw_normal_req | input | 1 | Hardware request to ring the normal doorbell |
| pend_o | output | 4 | Queues with a doorbell set and not halted |
| stop_o | output | 4 | Per-queue halt state |
| status_o | output | 8 | Read-back of doorbells and stop bits |

## Verification
Every doorbell and stop bit reaches `status_o` through no further register. A wrongly gated write, a lost completion or a wrong priority between set and clear therefore shows up at the ports in the cycle right after the edge that caused it. The bench runs a behavioural model of all eight bits and compares all three outputs after every edge, so the first divergence is reported at the step that caused it. A stop bit that clears early is the one error that needs later traffic to show. Repeated zero writes and completion strobes after a halt are there to expose it.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int NQ = 4;
  localparam int RW = 2 * NQ;

  typedef enum logic [1:0] {
    Q_LOW  = 2'd0,
    Q_NORM = 2'd1,
    Q_HIGH = 2'd2,
    Q_BCN  = 2'd3
  } txq_e;

  // Host doorbell field -> set requests that the host is allowed to make.
  function automatic logic [NQ-1:0] host_bell_set(logic [NQ-1:0] field, logic poll);
    logic [NQ-1:0] m;
    m = field;
    m[Q_BCN] = 1'b0;
    if (!poll) m[Q_NORM] = 1'b0;
    return m;
  endfunction

  // Hardware-originated doorbell set requests.
  function automatic logic [NQ-1:0] hw_bell_set(logic bcn, logic norm);
    logic [NQ-1:0] m;
    m = '0;
    m[Q_BCN]  = bcn;
    m[Q_NORM] = norm;
    return m;
  endfunction

  // Host stop field -> stop bits that are accepted in the current mode.
  function automatic logic [NQ-1:0] stop_accept(logic [NQ-1:0] field, logic poll);
    logic [NQ-1:0] m;
    m = field;
    if (poll) begin
      m[Q_BCN]  = 1'b0;
      m[Q_NORM] = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/txq_bell_cell.sv
module txq_bell_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic bell_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bell_o <= 1'b0;
    else if (set_i) bell_o <= 1'b1;
    else if (clr_i) bell_o <= 1'b0;
  end

  // R7: set has priority over a simultaneous completion
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> bell_o);
  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !bell_o);
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(bell_o));
endmodule

// File: rtl/txq_stop_bank.sv
module txq_stop_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] arm_i,
  output logic [N-1:0] stop_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_o <= '0;
    else        stop_o <= stop_o | arm_i;
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chk
      a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o[g] |=> stop_o[g]);
      a_r8_arm: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i[g] |=> stop_o[g]);
      a_r6_no_arm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i[g] && !stop_o[g]) |=> !stop_o[g]);
    end
  endgenerate
endmodule

// File: rtl/txq_doorbell.sv
module txq_doorbell
  import txq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_data,
  input  logic          poll_mode,
  input  logic [NQ-1:0] tx_done,
  input  logic          hw_beacon_req,
  input  logic          hw_normal_req,
  output logic [NQ-1:0] pend_o,
  output logic [NQ-1:0] stop_o,
  output logic [RW-1:0] status_o
);
  logic [NQ-1:0] bell_field, stop_field;
  logic [NQ-1:0] host_set, hw_set, bell_set, stop_arm;
  logic [NQ-1:0] bell_q, stop_q;

  assign bell_field = wr_data[RW-1:NQ];
  assign stop_field = wr_data[NQ-1:0];

  assign host_set = wr_en ? host_bell_set(bell_field, poll_mode) : '0;
  assign hw_set   = hw_bell_set(hw_beacon_req, hw_normal_req);
  assign bell_set = host_set | hw_set;
  assign stop_arm = wr_en ? stop_accept(stop_field, poll_mode) : '0;

  genvar q;
  generate
    for (q = 0; q < NQ; q++) begin : g_bell
      txq_bell_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (bell_set[q]),
        .clr_i (tx_done[q]),
        .bell_o(bell_q[q])
      );
    end
  endgenerate

  txq_stop_bank #(.N(NQ)) u_stop (
    .clk   (clk),
    .rst_n (rst_n),
    .arm_i (stop_arm),
    .stop_o(stop_q)
  );

  assign pend_o   = bell_q & ~stop_q;
  assign stop_o   = stop_q;
  assign status_o = {bell_q, stop_q};

  // R4: host cannot ring the beacon doorbell
  a_r4_beacon_host_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_beacon_req && !bell_q[Q_BCN]) |=> !bell_q[Q_BCN]);
  // R5: normal doorbell needs polling mode or hardware
  a_r5_normal_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!poll_mode && !hw_normal_req && !bell_q[Q_NORM]) |=> !bell_q[Q_NORM]);
  // R9: two stop bits locked out in polling mode
  a_r9_stop_bcn_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_mode && !stop_q[Q_BCN]) |=> !stop_q[Q_BCN]);
  a_r9_stop_norm_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_mode && !stop_q[Q_NORM]) |=> !stop_q[Q_NORM]);
  // R10: a halted queue never shows pending
  a_r10_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o & stop_o) == '0);
  // R1: state is clear in the first cycle after reset release
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (status_o == '0));
endmodule

// File: tb/txq_doorbell_tb_top.sv
`timescale 1ns/1ps
module txq_doorbell_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       poll_mode = 1'b0;
  logic [3:0] tx_done = '0;
  logic       hw_beacon_req = 1'b0;
  logic       hw_normal_req = 1'b0;
  logic [3:0] pend_o, stop_o;
  logic [7:0] status_o;

  int n_checks = 0;
  int n_fail = 0;
  bit mb[4];
  bit ms[4];

  always #2.5 clk = ~clk;

  txq_doorbell dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .poll_mode(poll_mode), .tx_done(tx_done), .hw_beacon_req(hw_beacon_req),
    .hw_normal_req(hw_normal_req), .pend_o(pend_o), .stop_o(stop_o),
    .status_o(status_o)
  );

  task automatic compare(string tag);
    logic [7:0] es;
    logic [3:0] ep, est;
    for (int q = 0; q < 4; q++) begin
      es[4+q] = mb[q];
      es[q]   = ms[q];
      est[q]  = ms[q];
      ep[q]   = mb[q] && !ms[q];
    end
    n_checks++;
    if (status_o !== es || pend_o !== ep || stop_o !== est) begin
      n_fail++;
      $display("FAIL %s: status=%h pend=%b stop=%b expected status=%h pend=%b stop=%b",
               tag, status_o, pend_o, stop_o, es, ep, est);
    end
  endtask

  task automatic step(string tag, bit w, logic [7:0] d, bit p, logic [3:0] dn,
                      bit hb, bit hn);
    @(negedge clk);
    wr_en = w; wr_data = d; poll_mode = p; tx_done = dn;
    hw_beacon_req = hb; hw_normal_req = hn;
    for (int q = 0; q < 4; q++) begin
      bit s;
      bit halt;
      if (q == 3)      s = hb;
      else if (q == 1) s = (w && d[5] && p) || hn;
      else             s = w && d[4+q];
      if (s)          mb[q] = 1'b1;
      else if (dn[q]) mb[q] = 1'b0;
      halt = w && d[q];
      if (p && (q == 3 || q == 1)) halt = 1'b0;
      if (halt) ms[q] = 1'b1;
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 0; wr_data = '0; tx_done = '0; hw_beacon_req = 0; hw_normal_req = 0;
    for (int q = 0; q < 4; q++) begin mb[q] = 0; ms[q] = 0; end
    @(posedge clk); #1;
    compare("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1 after release");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int q = 0; q < 4; q++) begin mb[q] = 0; ms[q] = 0; end
    do_reset();
    step("R2 high ring",        1, 8'h40, 0, 4'b0000, 0, 0);
    step("R2 low ring",         1, 8'h10, 0, 4'b0000, 0, 0);
    step("R6 zero write",       1, 8'h00, 0, 4'b0000, 0, 0);
    step("R3 high done",        0, 8'h00, 0, 4'b0100, 0, 0);
    step("R4 host beacon",      1, 8'h80, 0, 4'b0000, 0, 0);
    step("R4 hw beacon",        0, 8'h00, 0, 4'b0000, 1, 0);
    step("R3 beacon done",      0, 8'h00, 0, 4'b1000, 0, 0);
    step("R5 normal no poll",   1, 8'h20, 0, 4'b0000, 0, 0);
    step("R5 normal poll",      1, 8'h20, 1, 4'b0000, 0, 0);
    step("R3 normal done",      0, 8'h00, 1, 4'b0010, 0, 0);
    step("R5 hw normal",        0, 8'h00, 0, 4'b0000, 0, 1);
    step("R7 set vs done low",  1, 8'h10, 0, 4'b0001, 0, 0);
    step("R7 hw vs done bcn",   0, 8'h00, 0, 4'b1000, 1, 0);
    step("R3 low done",         0, 8'h00, 0, 4'b0001, 0, 0);
    step("R9 poll stop lock",   1, 8'h0A, 1, 4'b0000, 0, 0);
    step("R8 stop high",        1, 8'h04, 0, 4'b0000, 0, 0);
    step("R10 masked pend",     1, 8'h40, 0, 4'b0000, 0, 0);
    step("R8 hold zero write",  1, 8'h00, 1, 4'b1111, 0, 0);
    step("R9 poll stop low",    1, 8'h0B, 1, 4'b0000, 0, 0);
    step("R8 stop bcn norm",    1, 8'h0A, 0, 4'b0000, 0, 0);
    step("R10 all masked",      1, 8'h50, 1, 4'b0000, 1, 1);
    step("R11 readback",        0, 8'h00, 0, 4'b0000, 0, 0);
    do_reset();
    step("R1 ring after reset", 1, 8'hF0, 1, 4'b0000, 0, 0);
    step("R6 idle",             0, 8'h00, 0, 4'b0000, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule